// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one column command of a synchronous DRAM into the series of column addresses that the burst walks through. A column command is a single-cycle start strobe carrying the start column, a length code and an ordering select. The block loads these values, presents the start column on the next cycle, and then steps once per enabled clock until the burst is complete. Data capture and the read latency pipeline sit around it and are handled elsewhere.

Fixed-length bursts stay inside the aligned block of the burst length. In that block they count either upward with wrap-around or by XOR with the beat number. A full-page burst walks the whole 2048-column row, comes back to its start column and keeps going until a stop strobe ends it. A new column command replaces a running burst at once. A stop strobe that arrives without a full-page burst running is ignored, and a one-cycle illegal-stop flag reports it. A single-write select makes the burst one beat long. A low clock enable freezes all state.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `colValid`, `lastBeat` and `stopIllegal` are 0.
- R2: Sequential ordering. For burst length BL in {2,4,8}, beat k drives column bits [log2(BL)-1:0] to (start + k) mod BL. The upper bits stay equal to those of the start column.
- R3: Interleaved ordering (`interleave`=1, fixed length). Beat k drives the start column XOR k.
- R4: Full page (`lenCode`=3'b111). Beat k drives (start + k) mod 2048, with no end. After 2048 beats the column is back at the start column. `interleave` has no effect in this mode.
- R5: With a full-page burst running, a stop strobe sampled on an enabled clock clears `colValid` on that edge.
- R6: A stop strobe sampled on an enabled clock without a start, and with no full-page burst running, changes no burst state. `stopIllegal` is 1 during the following cycle only.
- R7: A start strobe during a running burst ends that burst. The new burst begins from the new start column. When start and stop arrive together, the start wins and the stop is not flagged.
- R8: With `singleWrite`=1 at the start strobe, the burst lasts exactly one beat, whatever `lenCode` holds.
- R9: While `ce` is 0, all strobes are ignored and `col`, `colValid` and `lastBeat` hold their values.
- R10: `lastBeat` is 1 exactly on beat BL-1 of a fixed-length burst. It is never 1 during a full-page burst. `colValid` falls after the last beat.
- R11: Length codes: 3'b000 is 1 beat, 3'b001 is 2, 3'b010 is 4, 3'b011 is 8 and 3'b111 is full page. The codes 3'b100 to 3'b110 behave as 1 beat.
- R12: A start strobe sampled on an enabled clock makes `colValid` 1 in the next cycle, with `col` equal to the start column (beat 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable; low freezes the block |
| startStb | input | 1 | Column command strobe |
| stopStb | input | 1 | Burst-stop strobe |
| startCol | input | 11 | Start column of the burst |
| lenCode | input | 3 | Burst length code (R11) |
| interleave | input | 1 | 1 selects interleaved ordering |
| singleWrite | input | 1 | 1 forces a one-beat burst |
| col | output | 11 | Current column |
| colValid | output | 1 | A burst beat is presented on `col` |
| lastBeat | output | 1 | Final beat of a fixed-length burst |
| stopIllegal | output | 1 | Stop strobe seen with no full-page burst running |

## Verification
The assertions take the strobes as clean single-cycle values sampled only when `ce` is high, and they take `startCol` as stable during the cycle of its strobe. The stimulus drives every input on the falling edge and holds each value for a whole cycle. It places suspend windows, stops and restarts both inside and outside running bursts, so that each assertion's antecedent is reached through legal input sequences only.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int COL_W = 11;
  localparam int LEN_W = 3;

  localparam logic [LEN_W-1:0] LEN_FULL = 3'b111;

  typedef struct packed {
    logic             load;
    logic             step;
    logic [COL_W-1:0] mask;
    logic             xorMode;
  } strobe_t;
endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
#(
  parameter int CW = COL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ce,
  input  logic             startStb,
  input  logic             stopStb,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             interleave,
  input  logic             singleWrite,
  output strobe_t          stb,
  output logic             colValid,
  output logic             lastBeat,
  output logic             stopIllegal
);
  logic          full;
  logic [CW-1:0] remain;
  logic [CW-1:0] lenMask;
  logic          isFull;
  logic          endNow;

  always_comb begin
    isFull = 1'b0;
    case (lenCode)
      3'b001:   lenMask = CW'(1);
      3'b010:   lenMask = CW'(3);
      3'b011:   lenMask = CW'(7);
      LEN_FULL: begin lenMask = '1; isFull = 1'b1; end
      default:  lenMask = '0;
    endcase
    if (singleWrite) begin
      lenMask = '0;
      isFull  = 1'b0;
    end
  end

  assign endNow = full ? stopStb : (remain == '0);

  always_comb begin
    stb.load    = ce & startStb;
    stb.step    = ce & ~startStb & colValid & ~endNow;
    stb.mask    = lenMask;
    stb.xorMode = interleave & ~isFull;
  end

  assign lastBeat = colValid & ~full & (remain == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colValid    <= 1'b0;
      full        <= 1'b0;
      remain      <= '0;
      stopIllegal <= 1'b0;
    end else if (ce) begin
      stopIllegal <= stopStb & ~startStb & ~(colValid & full);
      if (startStb) begin
        colValid <= 1'b1;
        full     <= isFull;
        remain   <= lenMask;
      end else if (colValid) begin
        if (endNow) colValid <= 1'b0;
        else        remain   <= remain - 1'b1;
      end
    end else begin
      stopIllegal <= 1'b0;
    end
  end

  a_r5_stop_ends: assert property (@(posedge clk) disable iff (!rstN)
    ce && stopStb && !startStb && colValid && full |=> !colValid);

  a_r6_stop_ignored: assert property (@(posedge clk) disable iff (!rstN)
    ce && stopStb && !startStb && colValid && !full && remain != '0
    |=> colValid && stopIllegal);

  a_r9_suspend_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ce |=> $stable(colValid) && $stable(remain) && !stopIllegal);

  a_r10_no_last_full: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !lastBeat);
endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int CW = COL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [CW-1:0] startCol,
  output logic [CW-1:0] col
);
  logic [CW-1:0] base;
  logic [CW-1:0] offset;
  logic [CW-1:0] mask;
  logic          xorMode;
  logic [CW-1:0] sum;

  assign sum = base + offset;
  assign col = xorMode ? (base ^ offset) : ((base & ~mask) | (sum & mask));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      base    <= '0;
      offset  <= '0;
      mask    <= '0;
      xorMode <= 1'b0;
    end else if (stb.load) begin
      base    <= startCol;
      offset  <= '0;
      mask    <= stb.mask;
      xorMode <= stb.xorMode;
    end else if (stb.step) begin
      offset <= (offset + 1'b1) & mask;
    end
  end

  a_r12_first_col: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> col == $past(startCol));

  a_r2_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    ((col ^ base) & ~mask) == '0);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int CW = COL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ce,
  input  logic             startStb,
  input  logic             stopStb,
  input  logic [CW-1:0]    startCol,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             interleave,
  input  logic             singleWrite,
  output logic [CW-1:0]    col,
  output logic             colValid,
  output logic             lastBeat,
  output logic             stopIllegal
);
  strobe_t stb;

  burst_col_ctrl #(.CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .ce(ce), .startStb(startStb), .stopStb(stopStb),
    .lenCode(lenCode), .interleave(interleave), .singleWrite(singleWrite),
    .stb(stb), .colValid(colValid), .lastBeat(lastBeat),
    .stopIllegal(stopIllegal)
  );

  burst_col_dp #(.CW(CW)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .startCol(startCol), .col(col)
  );
endmodule

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ce = 1'b1, startStb = 1'b0, stopStb = 1'b0;
  logic [10:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic interleave = 1'b0, singleWrite = 1'b0;
  logic [10:0] col;
  logic colValid, lastBeat, stopIllegal;

  int nTests = 0, nFail = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  burst_col_gen dut (
    .clk(clk), .rstN(rstN), .ce(ce), .startStb(startStb), .stopStb(stopStb),
    .startCol(startCol), .lenCode(lenCode), .interleave(interleave),
    .singleWrite(singleWrite), .col(col), .colValid(colValid),
    .lastBeat(lastBeat), .stopIllegal(stopIllegal)
  );

  // behavioural reference
  bit mValid = 0, mIll = 0, mIlv = 0;
  int mBase = 0, mBeat = 0, mLen = 1; // mLen 0 = full page

  function automatic int decodeLen(logic [2:0] c, logic sw);
    if (sw) return 1;
    case (c)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 0;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rstN) begin
      if (!ce) mIll = 0;
      else if (startStb) begin
        mIll = 0; mValid = 1; mBase = startCol; mBeat = 0;
        mLen = decodeLen(lenCode, singleWrite); mIlv = interleave;
      end else begin
        mIll = stopStb && !(mValid && mLen == 0);
        if (mValid) begin
          if (mLen == 0 && stopStb) mValid = 0;
          else if (mLen != 0 && mBeat == mLen - 1) mValid = 0;
          else mBeat = (mLen == 0) ? (mBeat + 1) % 2048 : mBeat + 1;
        end
      end
    end
  end

  function automatic int expCol();
    if (mLen == 0) return (mBase + mBeat) % 2048;
    if (mIlv) return mBase ^ mBeat;
    return (mBase & ~(mLen - 1)) | ((mBase + mBeat) % mLen);
  endfunction

  task automatic check(string what, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check("valid", colValid, mValid);
      check("illegal", stopIllegal, mIll);
      check("last", lastBeat, mValid && mLen != 0 && mBeat == mLen - 1);
      if (mValid) check("col", col, expCol());
    end
  end

  task automatic cmd(int c, int len, bit ilv, bit sw);
    @(negedge clk);
    startStb = 1; startCol = 11'(c); lenCode = 3'(len); interleave = ilv; singleWrite = sw;
    @(negedge clk);
    startStb = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stopPulse();
    @(negedge clk); stopStb = 1;
    @(negedge clk); stopStb = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        tag = "R1";
        check("reset valid", colValid, 0);
        check("reset last", lastBeat, 0);
        check("reset illegal", stopIllegal, 0);
        rstN = 1;
        tag = "R2"; cmd(11'h0D5, 2, 0, 0); idle(5);          // BL4 seq
        tag = "R2"; cmd(11'h2AF, 3, 0, 0); idle(9);          // BL8 seq
        tag = "R3"; cmd(11'h7A6, 3, 1, 0); idle(9);          // BL8 interleave
        tag = "R3"; cmd(11'h013, 1, 1, 0); idle(3);          // BL2 interleave
        tag = "R10"; cmd(11'h100, 0, 0, 0); idle(2);         // BL1
        tag = "R11"; cmd(11'h155, 5, 0, 0); idle(2);         // reserved code
        tag = "R4"; cmd(11'h7FE, 7, 1, 0); idle(2055);       // full page wrap
        tag = "R5"; stopPulse(); idle(3);
        tag = "R6"; cmd(11'h040, 3, 0, 0); idle(2); stopPulse(); idle(8);
        tag = "R6"; stopPulse(); idle(2);                    // idle stop
        tag = "R7"; cmd(11'h300, 3, 0, 0); idle(3); cmd(11'h45B, 2, 1, 0); idle(6);
        tag = "R7";
        @(negedge clk); startStb = 1; stopStb = 1; startCol = 11'h222; lenCode = 3'b010; interleave = 0;
        @(negedge clk); startStb = 0; stopStb = 0; idle(6);
        tag = "R8"; cmd(11'h6F1, 3, 0, 1); idle(3);
        tag = "R9"; cmd(11'h5C9, 3, 0, 0); idle(2);
        @(negedge clk); ce = 0; startStb = 1; stopStb = 1; startCol = 11'h001; idle(4);
        @(negedge clk); ce = 1; startStb = 0; stopStb = 0; idle(10);
        tag = "R12"; cmd(11'h3FF, 7, 0, 0); idle(4); stopPulse(); idle(3);
      end
      begin
        repeat (20000) @(posedge clk);
        nTests++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule